// File: doc/BRIEF.md
# ACPI Power-Management Timer with Event Registers

This block combines a free-running 24-bit power-management timer with a small set of fixed-hardware event registers: status, enable and control. The timer advances at the nominal 3,579,545 Hz rate. That rate is not taken from a dedicated oscillator. A phase accumulator produces it from the system clock by adding the tick rate every cycle and subtracting the clock rate whenever the sum reaches it. Over time the increments therefore match the ratio exactly.

When the count wraps from its all-ones value, the block sets the timer-overflow status flag. If the matching enable bit is set and the control register's interrupt-enable bit is 1, the block raises a level interrupt line. The overflow then clears the whole enable register, so a single interrupt results until software re-arms it.

Software reaches the registers over a byte-addressed bus that accepts byte, word and dword accesses. Data is right-aligned on the bus. Bits of status, enable and control that have no function here are held only as storage or read as zero.

Top module: `acpi_pm_timer`

## Requirements
- R1: The counter advances on exactly those cycles where an accumulator (reset to 0, adding TICK_HZ per clock) reaches SYS_CLK_HZ or more, after which SYS_CLK_HZ is subtracted. With the default 50 MHz clock, 5000 cycles give 357 to 358 increments.
- R2: An increment from 0xFFFFFF makes the count 0 and sets status bit 0 (timer overflow).
- R3: After reset, status reads 0x0000, enable reads 0x0000, control reads 0x0001, and the timer counts up from 0.
- R4: Offsets are status at 0–1, enable at 2–3, control at 4–5 and timer at 8–11. bus_size 0/1/2 selects 1/2/4 bytes, and bus byte j maps to offset addr+j. A dword read at 0 returns {enable, status}. Offsets 6, 7 and 12–15 read 0 and ignore writes.
- R5: Writing 1 to status bit 0 or bit 5 clears that bit, and writing 0 leaves it unchanged. All other status bits read 0.
- R6: Only enable bits 0, 5, 8 and 10 and control bits 0, 2 and 13 are writable. Every other bit reads 0.
- R7: A write to any timer byte replaces those bytes of the count. That cycle's increment is dropped, and counting resumes from the loaded value.
- R8: Timer reads are zero-extended, so bits 31:24 always read 0. Writes to offset 11 are ignored.
- R9: sci_o is high exactly when control bit 0 is 1 and either an overflow latch is set or some status bit is set together with its enable bit. The latch sets when an overflow occurs while enable bit 0 is 1. That overflow also clears the entire enable register.
- R10: sci_o falls in the cycle after software clears status bit 0, unless another enabled status bit is set. It also stays low while control bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_addr | input | 4 | Byte offset of the access |
| bus_size | input | 2 | Access width: 0 byte, 1 word, 2 dword |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Combinational read data for bus_addr/bus_size, right-aligned |
| sci_o | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that the clock rate is at least twice the tick rate, so two ticks never fall on adjacent cycles. They also assume that accesses are naturally aligned, with bus_size never 3. The stimulus writes and reads only aligned offsets of the three legal widths. The default parameters keep the clock-to-tick ratio near 14. Overflows are reached by loading counts just below the wrap point, which keeps each wrap inside a few hundred cycles.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  // status bit positions
  localparam int STS_OVF  = 0;
  localparam int STS_GBL  = 5;

  // writable / clearable masks
  localparam logic [15:0] STS_W1C_MASK = 16'h0021;
  localparam logic [15:0] EN_MASK      = 16'h0521;
  localparam logic [15:0] CTL_MASK     = 16'h2005;
  localparam logic [15:0] CTL_RESET    = 16'h0001;

  // register offsets
  localparam int OFS_STS = 0;
  localparam int OFS_EN  = 2;
  localparam int OFS_CTL = 4;
  localparam int OFS_TMR = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // does an access of size sz at base touch offset k?
  function automatic logic byte_hit(input logic [3:0] base, input logic [3:0] k,
                                    input logic [1:0] sz);
    logic [3:0] d;
    d = k - base;
    return ({1'b0, d} < {2'b00, size_bytes(sz)});
  endfunction

  // bus lane that carries offset k for an access at base
  function automatic logic [1:0] lane_of(input logic [3:0] base, input logic [3:0] k);
    logic [3:0] d;
    d = k - base;
    return d[1:0];
  endfunction

  // merge written bytes into a 16-bit register and apply a mask
  function automatic logic [15:0] merge16(input logic [15:0] old, input logic [1:0] be,
                                          input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [15:0] mask);
    logic [15:0] r;
    r = old;
    if (be[0]) r[7:0]  = b0;
    if (be[1]) r[15:8] = b1;
    return r & mask;
  endfunction

endpackage

// File: rtl/pmt_tick_gen.sv
module pmt_tick_gen #(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int TICK_HZ    = 3_579_545
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int ACC_W = $clog2(SYS_CLK_HZ) + 1;
  localparam logic [ACC_W-1:0] INC  = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] MODV = ACC_W'(SYS_CLK_HZ);

  logic [ACC_W-1:0] acc_q, acc_d, sum;

  function automatic logic [ACC_W-1:0] wrap_sub(input logic [ACC_W-1:0] s);
    return (s >= MODV) ? (s - MODV) : s;
  endfunction

  always_comb begin
    sum   = acc_q + INC;
    tick  = (sum >= MODV);
    acc_d = wrap_sub(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);  // R1

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int CNT_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic [(CNT_W+7)/8-1:0]     ld_be,
  input  logic [(CNT_W+7)/8-1:0][7:0] ld_bytes,
  output logic [CNT_W-1:0]           count,
  output logic                       wrap,
  output logic                       load
);
  localparam int NB = (CNT_W + 7) / 8;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [NB*8-1:0] merged;

  always_comb begin
    merged = (NB*8)'(count);
    for (int i = 0; i < NB; i++)
      if (ld_be[i]) merged[8*i +: 8] = ld_bytes[i];
  end

  assign load = |ld_be;
  assign wrap = tick && !load && (count == MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= merged[CNT_W-1:0];
    else if (wrap)   count <= '0;
    else if (tick)   count <= count + 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));  // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !wrap) |=> (count == $past(count) + 1'b1));  // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));  // R7

endmodule

// File: rtl/pmt_evt_regs.sv
module pmt_evt_regs
  import pmt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      wr_be,
  input  logic [5:0][7:0] wr_bytes,
  input  logic            ovf,
  output logic [15:0]     status,
  output logic [15:0]     enable,
  output logic [15:0]     control,
  output logic            one_shot,
  output logic            sci
);
  logic [15:0] sts_clr, sts_d, en_d, ctl_d;
  logic        ovf_latch, latch_d;

  always_comb begin
    sts_clr = merge16('0, wr_be[1:0], wr_bytes[0], wr_bytes[1], STS_W1C_MASK);
    one_shot = ovf && enable[STS_OVF];
    sts_d = (status & ~sts_clr);
    sts_d[STS_OVF] = sts_d[STS_OVF] | ovf;
    en_d  = one_shot ? '0
                     : merge16(enable, wr_be[3:2], wr_bytes[2], wr_bytes[3], EN_MASK);
    ctl_d = merge16(control, wr_be[5:4], wr_bytes[4], wr_bytes[5], CTL_MASK);
    if (one_shot)             latch_d = 1'b1;
    else if (!sts_d[STS_OVF]) latch_d = 1'b0;
    else                      latch_d = ovf_latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= '0;
      enable    <= '0;
      control   <= CTL_RESET;
      ovf_latch <= 1'b0;
    end else begin
      status    <= sts_d;
      enable    <= en_d;
      control   <= ctl_d;
      ovf_latch <= latch_d;
    end
  end

  assign sci = control[0] && (ovf_latch || |(status & enable));

  AST_OVF_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> status[STS_OVF]);  // R2
  AST_ONE_SHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    one_shot |=> (enable == '0));  // R9
  AST_SCI_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> status[STS_OVF]);  // R9
  AST_SCI_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[STS_OVF]) |-> !sci);  // R10

endmodule

// File: rtl/acpi_pm_timer.sv
module acpi_pm_timer
  import pmt_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int TICK_HZ    = 3_579_545,
  parameter int CNT_W      = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sci_o
);
  localparam int CNT_BYTES = (CNT_W + 7) / 8;
  localparam int LANES     = 4;
  localparam int NREG      = 16;

  logic                      tick, wrap, load, one_shot;
  logic [CNT_W-1:0]          count;
  logic [15:0]               status, enable, control;
  logic [5:0]                evt_be;
  logic [5:0][7:0]           evt_bytes;
  logic [CNT_BYTES-1:0]      tmr_be;
  logic [CNT_BYTES-1:0][7:0] tmr_bytes;
  logic [7:0]                view [NREG];

  // write steering: event registers at offsets 0..5
  for (genvar k = 0; k < 6; k++) begin : g_evt_wr
    assign evt_be[k]    = bus_wr && byte_hit(bus_addr, 4'(OFS_STS + k), bus_size);
    assign evt_bytes[k] = bus_wdata[8*lane_of(bus_addr, 4'(OFS_STS + k)) +: 8];
  end

  // write steering: timer bytes that hold count bits
  for (genvar k = 0; k < CNT_BYTES; k++) begin : g_tmr_wr
    assign tmr_be[k]    = bus_wr && byte_hit(bus_addr, 4'(OFS_TMR + k), bus_size);
    assign tmr_bytes[k] = bus_wdata[8*lane_of(bus_addr, 4'(OFS_TMR + k)) +: 8];
  end

  pmt_tick_gen #(.SYS_CLK_HZ(SYS_CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_be(tmr_be), .ld_bytes(tmr_bytes),
    .count(count), .wrap(wrap), .load(load)
  );

  pmt_evt_regs u_evt (
    .clk(clk), .rst_n(rst_n), .wr_be(evt_be), .wr_bytes(evt_bytes), .ovf(wrap),
    .status(status), .enable(enable), .control(control), .one_shot(one_shot),
    .sci(sci_o)
  );

  // byte view of the register space
  always_comb begin
    logic [8*LANES-1:0] tmr_ext;
    tmr_ext = (8*LANES)'(count);
    for (int k = 0; k < NREG; k++) view[k] = 8'h00;
    view[OFS_STS]   = status[7:0];
    view[OFS_STS+1] = status[15:8];
    view[OFS_EN]    = enable[7:0];
    view[OFS_EN+1]  = enable[15:8];
    view[OFS_CTL]   = control[7:0];
    view[OFS_CTL+1] = control[15:8];
    for (int k = 0; k < CNT_BYTES; k++) view[OFS_TMR+k] = tmr_ext[8*k +: 8];
  end

  // read lanes
  for (genvar j = 0; j < LANES; j++) begin : g_rd
    logic [3:0] idx;
    assign idx = bus_addr + 4'(j);
    assign bus_rdata[8*j +: 8] = (3'(j) < size_bytes(bus_size)) ? view[idx] : 8'h00;
  end

  AST_TIMER_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'(OFS_TMR) && bus_size == SZ_DWORD) |-> (bus_rdata[31:24] == 8'h00));  // R8
  AST_LOAD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wrap);  // R7

endmodule

// File: tb/acpi_pm_timer_bench.sv
`timescale 1ns/1ps
module acpi_pm_timer_bench;
  localparam int SYS_HZ  = 50_000_000;
  localparam int TICK_HZ = 3_579_545;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sci_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acpi_pm_timer #(.SYS_CLK_HZ(SYS_HZ), .TICK_HZ(TICK_HZ), .CNT_W(24)) u_acpi_pm_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sci_o(sci_o)
  );

  // ---------------- reference model ----------------
  longint      m_acc;
  logic [23:0] m_cnt;
  logic [15:0] m_sts, m_en, m_ctl, m_clr;
  bit          m_latch, m_tick, m_ovf, m_ld, m_en0;
  bit          wv [16];
  logic [7:0]  wb [16];
  logic [31:0] m_tmp;

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] mbyte(input int k);
    case (k)
      0: return m_sts[7:0];   1: return m_sts[15:8];
      2: return m_en[7:0];    3: return m_en[15:8];
      4: return m_ctl[7:0];   5: return m_ctl[15:8];
      8: return m_cnt[7:0];   9: return m_cnt[15:8];
      10: return m_cnt[23:16];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a, input logic [1:0] s);
    logic [31:0] r = '0;
    for (int j = 0; j < nbytes(s); j++) r[8*j +: 8] = mbyte((int'(a) + j) % 16);
    return r;
  endfunction

  function automatic bit model_sci();
    return m_ctl[0] && (m_latch || (|(m_sts & m_en)));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = '0; m_sts = '0; m_en = '0; m_ctl = 16'h0001; m_latch = 0;
    end else begin
      for (int k = 0; k < 16; k++) begin wv[k] = 0; wb[k] = 8'h00; end
      if (bus_wr)
        for (int j = 0; j < nbytes(bus_size); j++) begin
          wv[(int'(bus_addr) + j) % 16] = 1;
          wb[(int'(bus_addr) + j) % 16] = bus_wdata[8*j +: 8];
        end
      m_acc = m_acc + TICK_HZ;
      m_tick = (m_acc >= SYS_HZ);
      if (m_tick) m_acc = m_acc - SYS_HZ;
      m_ld = wv[8] || wv[9] || wv[10] || wv[11];
      m_ovf = 0;
      if (m_ld) begin
        m_tmp = {8'h00, m_cnt};
        for (int j = 0; j < 4; j++) if (wv[8+j]) m_tmp[8*j +: 8] = wb[8+j];
        m_cnt = m_tmp[23:0];
      end else if (m_tick) begin
        if (m_cnt == 24'hFFFFFF) begin m_cnt = '0; m_ovf = 1; end
        else m_cnt = m_cnt + 24'd1;
      end
      m_clr = '0;
      if (wv[0]) m_clr[7:0]  = wb[0];
      if (wv[1]) m_clr[15:8] = wb[1];
      m_clr = m_clr & 16'h0021;
      m_en0 = m_en[0];
      m_sts = (m_sts & ~m_clr) | {15'b0, m_ovf};
      if (m_ovf && m_en0) m_en = '0;
      else begin
        if (wv[2]) m_en[7:0]  = wb[2] & 8'h21;
        if (wv[3]) m_en[15:8] = wb[3] & 8'h05;
      end
      if (wv[4]) m_ctl[7:0]  = wb[4] & 8'h05;
      if (wv[5]) m_ctl[15:8] = wb[5] & 8'h20;
      if (m_ovf && m_en0) m_latch = 1;
      else if (!m_sts[0]) m_latch = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bus_rdata == model_read(bus_addr, bus_size), "R4 per-cycle read",
          bus_rdata, model_read(bus_addr, bus_size));
      chk(sci_o == model_sci(), "R9 per-cycle sci", {31'b0, sci_o}, {31'b0, model_sci()});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); #2;
    bus_wr = 1'b0; bus_addr = a; bus_size = s;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_sci(input int maxc);
    for (int i = 0; i < maxc && !sci_o; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  logic [31:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset values
    rd(4'd4, 2'd1, v); chk(v == 32'h0001, "R3 control reset", v, 32'h0001);
    rd(4'd0, 2'd2, v); chk(v == 32'h0, "R3 status/enable reset", v, 32'h0);
    rd(4'd8, 2'd2, v); chk(v < 32'd4, "R3 timer starts near zero", v, 32'h0);

    // R6 writable masks
    wr(4'd2, 2'd1, 32'hFFFF);
    rd(4'd2, 2'd1, v); chk(v == 32'h0521, "R6 enable mask", v, 32'h0521);
    wr(4'd4, 2'd1, 32'hFFFF);
    rd(4'd4, 2'd1, v); chk(v == 32'h2005, "R6 control mask", v, 32'h2005);
    wr(4'd4, 2'd1, 32'h0000);
    rd(4'd4, 2'd1, v); chk(v == 32'h0000, "R6 control cleared", v, 32'h0);

    // R4 map and dword packing
    wr(4'd2, 2'd1, 32'h0121);
    rd(4'd0, 2'd2, v); chk(v == 32'h0121_0000, "R4 dword {enable,status}", v, 32'h01210000);
    rd(4'd3, 2'd0, v); chk(v == 32'h01, "R4 byte lane offset 3", v, 32'h01);
    wr(4'd6, 2'd1, 32'hBEEF);
    rd(4'd6, 2'd1, v); chk(v == 32'h0, "R4 unmapped offset 6", v, 32'h0);
    wr(4'd12, 2'd2, 32'hFFFF_FFFF);
    rd(4'd12, 2'd2, v); chk(v == 32'h0, "R4 unmapped offset 12", v, 32'h0);
    wr(4'd2, 2'd1, 32'h0000);
    wr(4'd4, 2'd1, 32'h0001);

    // R7 / R8 timer load and zero extension
    wr(4'd8, 2'd2, 32'h1234_5678);
    rd(4'd8, 2'd2, v);
    chk(v == 32'h0034_5678 || v == 32'h0034_5679, "R7 timer load", v, 32'h00345678);
    chk(v[31:24] == 8'h00, "R8 timer upper byte zero", v, 32'h0);
    wr(4'd11, 2'd0, 32'hAA);
    rd(4'd11, 2'd0, v); chk(v == 32'h0, "R8 offset 11 ignores writes", v, 32'h0);
    wr(4'd9, 2'd0, 32'h00);
    rd(4'd8, 2'd2, v);
    chk(v[15:8] == 8'h00 && v[23:16] == 8'h34, "R7 byte load", v, 32'h003400ff);

    // R1 rate
    wr(4'd8, 2'd2, 32'h0);
    repeat (4998) @(negedge clk);
    rd(4'd8, 2'd2, v);
    chk(v >= 32'd357 && v <= 32'd359, "R1 tick rate over 5000 cycles", v, 32'd358);

    // R2 / R9 overflow with enable
    wr(4'd2, 2'd1, 32'h0001);
    wr(4'd8, 2'd2, 32'h00FF_FFF8);
    wait_sci(400);
    @(negedge clk);
    chk(sci_o == 1'b1, "R9 sci on enabled overflow", {31'b0, sci_o}, 32'h1);
    rd(4'd0, 2'd1, v); chk(v[0] == 1'b1, "R2 overflow status", v, 32'h1);
    rd(4'd2, 2'd1, v); chk(v == 32'h0, "R9 one-shot clears enable", v, 32'h0);
    rd(4'd8, 2'd2, v); chk(v < 32'h10, "R2 count wrapped to zero", v, 32'h0);

    // R5 write-0 and other bits
    wr(4'd0, 2'd1, 32'h0000);
    rd(4'd0, 2'd1, v); chk(v[0] == 1'b1 && sci_o, "R5 write 0 keeps status", v, 32'h1);
    wr(4'd0, 2'd1, 32'h0020);
    rd(4'd0, 2'd1, v); chk(v[0] == 1'b1, "R5 clearing bit 5 leaves bit 0", v, 32'h1);
    // R10 clear drops sci
    wr(4'd0, 2'd0, 32'h01);
    chk(sci_o == 1'b0, "R10 sci drops after clear", {31'b0, sci_o}, 32'h0);
    rd(4'd0, 2'd1, v); chk(v == 32'h0, "R5 status cleared", v, 32'h0);
    wr(4'd0, 2'd1, 32'hFFFF);
    rd(4'd0, 2'd1, v); chk(v == 32'h0, "R5 unused status bits read 0", v, 32'h0);

    // R9 overflow without enable, then level on re-enable
    wr(4'd8, 2'd2, 32'h00FF_FFF8);
    repeat (300) @(negedge clk);
    chk(sci_o == 1'b0, "R9 no sci without enable", {31'b0, sci_o}, 32'h0);
    rd(4'd0, 2'd1, v); chk(v[0] == 1'b1, "R2 status set without enable", v, 32'h1);
    wr(4'd2, 2'd1, 32'h0001);
    chk(sci_o == 1'b1, "R9 level on enable with pending status", {31'b0, sci_o}, 32'h1);
    wr(4'd4, 2'd1, 32'h0000);
    chk(sci_o == 1'b0, "R10 sci low with control bit 0 clear", {31'b0, sci_o}, 32'h0);
    wr(4'd0, 2'd2, 32'h0000_0001);
    wr(4'd4, 2'd1, 32'h0001);
    chk(sci_o == 1'b0, "R10 sci stays low after clear", {31'b0, sci_o}, 32'h0);

    repeat (50) @(negedge clk);
    finish_run();
  end

endmodule